// File: doc/BRIEF.md
# Low-Power Event Timer with Compare-Driven Output

This block is a 16-bit up-counter behind a plain word-addressed write strobe and a combinational read port. It either advances on every cycle of its clock or advances on edges of one external trigger line, picked from sixteen inputs. The picked line is passed through a two-flop synchronizer and an edge detector, so each qualifying edge is counted once.

Two thresholds are compared against the counter. A match and a counter wrap are the three event sources. Each source has its own enable, a sticky status flag with an interrupt mask, and an action on a single output level: wrap sets it, threshold A clears it, threshold B sets it. The two thresholds can also each restart the counter from zero. The output level passes through an optional inversion and a master enable before it reaches the pin. Software preloads the counter, or snapshots it, through a staging register by setting self-clearing command bits. A debug-halt input can be allowed to freeze counting.

Top module: `lp_event_timer`

## Requirements
- R1: After reset, all four registers read 0, and `irq_o` and `pin_o` are 0. The registers are at word 0 (control), word 1 (staging count), word 2 (thresholds) and word 3 (status).
- R2: Control bits [1:0] pick the count source. 0 advances the counter once per clock while running. 1 counts rising trigger edges, 2 counts falling edges and 3 counts both edges.
- R3: Control bits [5:2] select which of `trig_i[15:0]` is counted. Activity on any other line has no effect, and every edge of the selected line advances the counter by exactly one.
- R4: Writing 1 to control bit 6 copies the staging register into the counter on the next clock. The bit then reads 0.
- R5: Writing 1 to control bit 7 copies the counter into the staging register on the next clock. The bit then reads 0, and the staging word shows the snapshot.
- R6: While control bit 21 (run) is 0, the counter holds its value and no compare or wrap event occurs.
- R7: The threshold word holds threshold A in bits [15:0] and threshold B in bits [31:16]. Each has its own enable (control bits 8 and 9). When the counter equals an enabled threshold as it steps, that threshold's event fires. If its restart bit (18 for A, 19 for B) is set, the counter goes to 0 instead of incrementing.
- R8: A wrap event fires when the counter steps from 0xFFFF to 0x0000.
- R9: Status bits 0, 1 and 2 latch the wrap, A and B events, and writing 1 to a bit clears it. If an event and a clear hit the same flag in the same cycle, the flag stays set.
- R10: `irq_o` is high when any status flag is set whose mask bit is set. The mask bits are control bits 12 (wrap), 13 (A) and 14 (B).
- R11: Action bits 15 (wrap sets), 16 (A clears) and 17 (B sets) drive an internal level. When a clear and a set arrive in the same cycle, the clear wins. The pin shows this level XOR control bit 11, gated by control bit 10.
- R12: When control bit 20 is 1, a high `dbg_halt_i` freezes counting. When bit 20 is 0, the halt input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| trig_i | input | 16 | External trigger lines |
| dbg_halt_i | input | 1 | Debug-halt request |
| irq_o | output | 1 | Interrupt request |
| pin_o | output | 1 | Timer output pin |

## Verification
Two pairs of functions can coincide in one cycle. In the first pair, a software clear of a status flag meets a new event for that flag. The bench preloads the counter, starts it, and times the status write so that it lands on the very edge at which the counter steps off threshold A. It then requires the flag to read 1 afterwards, and 0 after a second, quiet clear. In the second pair, a clearing and a setting output action fall together. Here both thresholds are set to the same value with both actions enabled, starting from a set level, and the pin must read 0. Runs with only one action enabled confirm that each action works on its own.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

  localparam int CNT_W  = 16;
  localparam int TRIG_N = 16;
  localparam int SEL_W  = $clog2(TRIG_N);
  localparam int FLAG_N = 3;
  localparam int RSV_W  = 32 - 18 - SEL_W;

  localparam int EV_WRAP = 0;
  localparam int EV_A    = 1;
  localparam int EV_B    = 2;

  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_STAGE = 2'd1;
  localparam logic [1:0] A_THR   = 2'd2;
  localparam logic [1:0] A_STAT  = 2'd3;

  typedef enum logic [1:0] {
    CM_FREE = 2'd0,
    CM_RISE = 2'd1,
    CM_FALL = 2'd2,
    CM_BOTH = 2'd3
  } cnt_mode_e;

  typedef struct packed {
    logic [RSV_W-1:0] rsv;
    logic             run;       // 21
    logic             dbg_hold;  // 20
    logic             b_restart; // 19
    logic             a_restart; // 18
    logic             b_act;     // 17 sets level
    logic             a_act;     // 16 clears level
    logic             wrap_act;  // 15 sets level
    logic             b_ien;     // 14
    logic             a_ien;     // 13
    logic             wrap_ien;  // 12
    logic             invert;    // 11
    logic             pin_en;    // 10
    logic             b_en;      // 9
    logic             a_en;      // 8
    logic             capture;   // 7
    logic             load;      // 6
    logic [SEL_W-1:0] sel;       // 5:2
    cnt_mode_e        mode;      // 1:0
  } ctrl_t;

  // Decide whether the transition prev -> cur is one the mode counts.
  function automatic logic edge_counts(cnt_mode_e m, logic prev, logic cur);
    case (m)
      CM_RISE: return cur & ~prev;
      CM_FALL: return ~cur & prev;
      CM_BOTH: return cur ^ prev;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/lpt_trig_sync.sv
module lpt_trig_sync
  import lpt_pkg::*;
#(
  parameter int N  = TRIG_N,
  parameter int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  trig_i,
  input  logic [SW-1:0] sel_i,
  input  cnt_mode_e     mode_i,
  output logic          edge_o
);

  logic       raw;
  logic [2:0] sh_q;  // [0] first flop, [1] synchronized, [2] previous

  assign raw = trig_i[sel_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[1:0], raw};
  end

  assign edge_o = edge_counts(mode_i, sh_q[2], sh_q[1]);

  p_free_no_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == CM_FREE) |-> !edge_o);

  p_edge_needs_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |-> (sh_q[2] != sh_q[1]));

endmodule

// File: rtl/lpt_counter.sv
module lpt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] thr_a_i,
  input  logic [W-1:0] thr_b_i,
  input  logic         a_en_i,
  input  logic         b_en_i,
  input  logic         a_restart_i,
  input  logic         b_restart_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_evt_o,
  output logic         a_evt_o,
  output logic         b_evt_o
);

  localparam logic [W-1:0] TOP = '1;

  function automatic logic [W-1:0] next_count(logic [W-1:0] c, logic restart);
    return restart ? '0 : c + 1'b1;
  endfunction

  logic [W-1:0] cnt_q;
  logic         step;
  logic         restart;

  assign step       = tick_i & ~load_i;
  assign a_evt_o    = step & a_en_i & (cnt_q == thr_a_i);
  assign b_evt_o    = step & b_en_i & (cnt_q == thr_b_i);
  assign restart    = (a_evt_o & a_restart_i) | (b_evt_o & b_restart_i);
  assign wrap_evt_o = step & (cnt_q == TOP) & ~restart;
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (step)   cnt_q <= next_count(cnt_q, restart);
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(cnt_q));

  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !restart) |=> (cnt_q == W'($past(cnt_q) + 1'b1)));

  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && restart) |=> (cnt_q == '0));

  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt_o |=> (cnt_q == '0));

  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i)));

endmodule

// File: rtl/lpt_flags.sv
module lpt_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] ien_i,
  output logic [N-1:0] flag_o,
  output logic         irq_o
);

  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= evt_i[i] | (flag_q[i] & ~clr_i[i]);
    end

    p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[i] |=> flag_q[i]);

    p_quiet_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !evt_i[i]) |=> !flag_q[i]);
  end

  assign flag_o = flag_q;
  assign irq_o  = |(flag_q & ien_i);

endmodule

// File: rtl/lpt_out_ctl.sv
module lpt_out_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic inv_i,
  input  logic en_i,
  output logic pin_o
);

  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     level_q <= 1'b0;
    else if (clr_i) level_q <= 1'b0;
    else if (set_i) level_q <= 1'b1;
  end

  assign pin_o = en_i & (level_q ^ inv_i);

  p_clear_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !level_q);

  p_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> level_q);

endmodule

// File: rtl/lp_event_timer.sv
module lp_event_timer
  import lpt_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [TRIG_N-1:0] trig_i,
  input  logic              dbg_halt_i,
  output logic              irq_o,
  output logic              pin_o
);

  localparam int HALF = 16;

  ctrl_t           ctrl_q;
  logic [CW-1:0]   stage_q;
  logic [CW-1:0]   thr_a_q;
  logic [CW-1:0]   thr_b_q;
  logic [CW-1:0]   cnt;
  logic [FLAG_N-1:0] flags;
  logic [FLAG_N-1:0] evts;
  logic [FLAG_N-1:0] clrs;
  logic [FLAG_N-1:0] iens;
  logic            trig_edge;
  logic            freeze;
  logic            tick;
  logic            wrap_evt, a_evt, b_evt;
  logic            lvl_set, lvl_clr;
  logic            wr_ctrl, wr_stage, wr_thr, wr_stat;

  assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
  assign wr_stage = bus_wr && (bus_addr == A_STAGE);
  assign wr_thr   = bus_wr && (bus_addr == A_THR);
  assign wr_stat  = bus_wr && (bus_addr == A_STAT);

  // Control word; command bits drop back to 0 one cycle after they are set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q     <= ctrl_t'(bus_wdata);
      ctrl_q.rsv <= '0;
    end else begin
      ctrl_q.load    <= 1'b0;
      ctrl_q.capture <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              stage_q <= '0;
    else if (ctrl_q.capture) stage_q <= cnt;
    else if (wr_stage)       stage_q <= bus_wdata[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_a_q <= '0;
      thr_b_q <= '0;
    end else if (wr_thr) begin
      thr_a_q <= bus_wdata[CW-1:0];
      thr_b_q <= bus_wdata[HALF +: CW];
    end
  end

  lpt_trig_sync #(.N(TRIG_N), .SW(SEL_W)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (trig_i),
    .sel_i  (ctrl_q.sel),
    .mode_i (ctrl_q.mode),
    .edge_o (trig_edge)
  );

  assign freeze = ctrl_q.dbg_hold & dbg_halt_i;
  assign tick   = ctrl_q.run & ~freeze & ((ctrl_q.mode == CM_FREE) | trig_edge);

  lpt_counter #(.W(CW)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .load_i      (ctrl_q.load),
    .load_val_i  (stage_q),
    .thr_a_i     (thr_a_q),
    .thr_b_i     (thr_b_q),
    .a_en_i      (ctrl_q.a_en),
    .b_en_i      (ctrl_q.b_en),
    .a_restart_i (ctrl_q.a_restart),
    .b_restart_i (ctrl_q.b_restart),
    .cnt_o       (cnt),
    .wrap_evt_o  (wrap_evt),
    .a_evt_o     (a_evt),
    .b_evt_o     (b_evt)
  );

  always_comb begin
    evts          = '0;
    evts[EV_WRAP] = wrap_evt;
    evts[EV_A]    = a_evt;
    evts[EV_B]    = b_evt;
    iens          = '0;
    iens[EV_WRAP] = ctrl_q.wrap_ien;
    iens[EV_A]    = ctrl_q.a_ien;
    iens[EV_B]    = ctrl_q.b_ien;
    clrs          = wr_stat ? bus_wdata[FLAG_N-1:0] : '0;
  end

  lpt_flags #(.N(FLAG_N)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evts),
    .clr_i  (clrs),
    .ien_i  (iens),
    .flag_o (flags),
    .irq_o  (irq_o)
  );

  assign lvl_set = (wrap_evt & ctrl_q.wrap_act) | (b_evt & ctrl_q.b_act);
  assign lvl_clr = a_evt & ctrl_q.a_act;

  lpt_out_ctl u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (lvl_set),
    .clr_i (lvl_clr),
    .inv_i (ctrl_q.invert),
    .en_i  (ctrl_q.pin_en),
    .pin_o (pin_o)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata = 32'(ctrl_q);
      A_STAGE: bus_rdata[CW-1:0] = stage_q;
      A_THR: begin
        bus_rdata[CW-1:0]    = thr_a_q;
        bus_rdata[HALF +: CW] = thr_b_q;
      end
      default: bus_rdata[FLAG_N-1:0] = flags;
    endcase
  end

  p_stopped_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.run |-> !(wrap_evt || a_evt || b_evt));

  p_halt_freezes_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.dbg_hold && dbg_halt_i && !ctrl_q.load) |=> $stable(cnt));

  p_load_self_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.load && !wr_ctrl) |=> !ctrl_q.load);

  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.capture |=> (stage_q == $past(cnt)));

endmodule

// File: tb/lp_event_timer_test.sv
module lp_event_timer_test;

  localparam int CLK_NS = 10;

  localparam logic [31:0] LOAD  = 32'h1 << 6;
  localparam logic [31:0] CAP   = 32'h1 << 7;
  localparam logic [31:0] A_EN  = 32'h1 << 8;
  localparam logic [31:0] B_EN  = 32'h1 << 9;
  localparam logic [31:0] PINEN = 32'h1 << 10;
  localparam logic [31:0] INV   = 32'h1 << 11;
  localparam logic [31:0] W_IEN = 32'h1 << 12;
  localparam logic [31:0] W_ACT = 32'h1 << 15;
  localparam logic [31:0] A_ACT = 32'h1 << 16;
  localparam logic [31:0] B_ACT = 32'h1 << 17;
  localparam logic [31:0] A_RST = 32'h1 << 18;
  localparam logic [31:0] B_RST = 32'h1 << 19;
  localparam logic [31:0] DHOLD = 32'h1 << 20;
  localparam logic [31:0] RUN   = 32'h1 << 21;

  // {sel[4], driven line[4], mode[2], pulses[6], expected count[16]}
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    {4'd3,  4'd3,  2'd1, 6'd3, 16'd3},
    {4'd3,  4'd3,  2'd2, 6'd4, 16'd4},
    {4'd7,  4'd7,  2'd3, 6'd3, 16'd6},
    {4'd15, 4'd15, 2'd1, 6'd5, 16'd5},
    {4'd0,  4'd9,  2'd3, 6'd4, 16'd0},
    {4'd12, 4'd12, 2'd3, 6'd1, 16'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] trig;
  logic        dbg_halt;
  logic        irq;
  logic        pin;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  lp_event_timer uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .trig_i     (trig),
    .dbg_halt_i (dbg_halt),
    .irq_o      (irq),
    .pin_o      (pin)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Called at a falling edge; the write takes effect on the next rising edge.
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic preload(input logic [31:0] v, input logic [31:0] base);
    wr(2'd1, v);
    wr(2'd0, base | LOAD);
  endtask

  // Stops the counter and snapshots it in one write.
  task automatic snap(input logic [31:0] base, output logic [31:0] d);
    wr(2'd0, base | CAP);
    idle(1);
    rd(2'd1, d);
  endtask

  task automatic pulse(input int line);
    trig[line] = 1'b1;
    idle(3);
    trig[line] = 1'b0;
    idle(3);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2, base;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    trig = '0; dbg_halt = 1'b0;
    idle(3);
    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check($sformatf("R1 reg%0d after reset", a), d, 32'h0);
    end
    check("R1 irq after reset", {31'd0, irq}, 32'd0);
    check("R1 pin after reset", {31'd0, pin}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R2/R3: trigger modes and line selection, table driven
    for (int i = 0; i < NV; i++) begin
      logic [3:0]  sel  = VEC[i][31:28];
      logic [3:0]  line = VEC[i][27:24];
      logic [1:0]  md   = VEC[i][23:22];
      logic [5:0]  np   = VEC[i][21:16];
      logic [15:0] exp  = VEC[i][15:0];
      base = {26'd0, sel, md};
      preload(32'd0, base);
      wr(2'd0, base | RUN);
      for (int p = 0; p < int'(np); p++) pulse(int'(line));
      idle(6);
      snap(base, d);
      check($sformatf("R2 R3 vector %0d count", i), d, {16'd0, exp});
    end

    // R2: free running, 10 ticks
    preload(32'd0, 32'd0);
    wr(2'd0, RUN);
    idle(9);
    snap(32'd0, d);
    check("R2 free-run count", d, 32'd10);

    // R4: load self-clears and lands in the counter
    preload(32'h1234, 32'd0);
    idle(1);
    rd(2'd0, d);
    check("R4 load bit self-clear", d & LOAD, 32'd0);
    snap(32'd0, d);
    check("R4 loaded value", d, 32'h1234);
    // R5: capture bit self-clears
    rd(2'd0, d);
    check("R5 capture bit self-clear", d & CAP, 32'd0);
    // R6: stopped counter holds
    wr(2'd1, 32'hBEEF);
    idle(10);
    snap(32'd0, d);
    check("R6 stopped counter holds", d, 32'h1234);

    // R8/R10/R11: wrap event
    base = PINEN | W_ACT | W_IEN;
    preload(32'hFFFE, base);
    wr(2'd0, base | RUN);
    idle(2);
    snap(base, d);
    check("R8 count after wrap", d, 32'd1);
    rd(2'd3, d);
    check("R8 wrap flag", d, 32'd1);
    check("R10 irq on masked-in flag", {31'd0, irq}, 32'd1);
    check("R11 wrap sets pin", {31'd0, pin}, 32'd1);
    wr(2'd0, PINEN | W_ACT);
    check("R10 irq masked", {31'd0, irq}, 32'd0);
    wr(2'd0, PINEN | INV);
    check("R11 inverted pin", {31'd0, pin}, 32'd0);
    wr(2'd0, 32'd0);
    check("R11 pin gated off", {31'd0, pin}, 32'd0);
    wr(2'd0, W_IEN);
    check("R10 irq re-enabled", {31'd0, irq}, 32'd1);
    wr(2'd3, 32'd1);
    rd(2'd3, d);
    check("R9 write-one clears wrap flag", d, 32'd0);
    check("R10 irq after clear", {31'd0, irq}, 32'd0);

    // R11: clear wins when A and B fire together
    wr(2'd2, {16'd2, 16'd2});
    base = A_EN | B_EN | A_ACT | B_ACT | PINEN;
    preload(32'd0, base);
    wr(2'd0, base | RUN);
    idle(2);
    snap(base, d);
    check("R7 count at coincident thresholds", d, 32'd3);
    check("R11 clear beats set", {31'd0, pin}, 32'd0);
    rd(2'd3, d);
    check("R7 both threshold flags", d, 32'd6);
    base = A_EN | B_EN | B_ACT | PINEN;
    preload(32'd0, base);
    wr(2'd0, base | RUN);
    idle(2);
    snap(base, d);
    check("R11 threshold B sets pin", {31'd0, pin}, 32'd1);
    base = A_EN | A_ACT | PINEN;
    preload(32'd0, base);
    wr(2'd0, base | RUN);
    idle(2);
    snap(base, d);
    check("R11 threshold A clears pin", {31'd0, pin}, 32'd0);

    // R7: restarts, period threshold+1
    wr(2'd2, {16'd0, 16'd5});
    base = A_EN | A_RST;
    preload(32'd0, base);
    wr(2'd0, base | RUN);
    idle(19);
    snap(base, d);
    check("R7 restart on A (20 ticks)", d, 32'd2);
    wr(2'd2, {16'd3, 16'd0});
    base = B_EN | B_RST;
    preload(32'd0, base);
    wr(2'd0, base | RUN);
    idle(10);
    snap(base, d);
    check("R7 restart on B (11 ticks)", d, 32'd3);

    // R9: event and clear in the same cycle; flag A is already set
    wr(2'd2, {16'd0, 16'd4});
    base = A_EN;
    preload(32'd0, base);
    wr(2'd0, base | RUN);
    idle(4);
    wr(2'd3, 32'd2);
    wr(2'd0, base);
    rd(2'd3, d);
    check("R9 event beats clear", d & 32'd2, 32'd2);
    wr(2'd3, 32'd2);
    rd(2'd3, d);
    check("R9 quiet clear", d & 32'd2, 32'd0);

    // R12: debug halt
    dbg_halt = 1'b1;
    preload(32'd0, DHOLD);
    wr(2'd0, DHOLD | RUN);
    idle(9);
    snap(DHOLD, d);
    check("R12 frozen under halt", d, 32'd0);
    preload(32'd0, 32'd0);
    wr(2'd0, RUN);
    idle(9);
    snap(32'd0, d2);
    check("R12 halt ignored when disabled", d2, 32'd10);
    dbg_halt = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule